// File: doc/BRIEF.md
# Page-Bounded Stream Prefetcher

This block watches the demand traffic of a second-level cache and predicts which 64-byte lines will be wanted next. Each request carries a line address, a miss/hit flag and an access type: instruction fetch, data read or read-for-ownership. The block keeps a small table of streams. Each stream is tied to one 4 KB page, which holds 64 lines. A data stream learns from successive accesses whether it climbs or descends through its page. Once the direction is confirmed, each access to the stream pushes a burst of up to four line addresses. The burst starts at the line next to the access and moves in the stream's direction.

Bursts never leave the page. The one exception is a stream whose access lands on the last line of its page in its direction. That stream emits a single prefetch for the nearest line of the adjacent page and then moves itself to that page. Instruction streams skip training and always run upward. Generated addresses pass through a four-entry queue to a valid/ready output, and each carries the type of the stream that produced it. Cache lookup, duplicate filtering and the memory path belong to the surrounding logic.

Top module: `page_stream_prefetcher`

## Requirements
- R1: After a synchronous active-low reset the table holds no stream and `pf_valid` is low.
- R2: A miss (`req_miss`=1) to a page that no stream covers allocates a stream for that page. A hit (`req_miss`=0) to an uncovered page is ignored and creates nothing.
- R3: A data stream issues nothing until it has seen two successive in-window steps of the same sign after allocation. The second such step confirms the direction and issues at once.
- R4: An access at line offset L of an upward stream issues lines L+1, L+2, L+3, L+4 of the same page, nearest first.
- R5: An access at line offset L of a downward stream issues lines L-1 through L-4 of the same page, nearest first.
- R6: An instruction stream (type 0) issues an upward burst on its allocating miss and on every later access, whatever the sign of the step.
- R7: Burst lines that would fall outside the page (offset above 63 or below 0) are dropped. The rest of the burst is kept.
- R8: An issuing access at offset 63 of an upward stream, or at offset 0 of a downward stream, issues exactly one line: offset 0 of the next page, or offset 63 of the previous page. The stream then covers that page, keeps its direction, and takes that line as its last access.
- R9: Every prefetch carries the type of its stream, encoded 0 instruction, 1 data read, 2 read-for-ownership. The value 3 never appears.
- R10: A step larger than WIN lines (default 16) returns a data stream to the untrained state. A step of exactly WIN lines still counts. A repeated access to the same line issues nothing and changes no training.
- R11: The output queue holds four addresses and presents them in FIFO order. New lines fill only free slots, and the excess is dropped without disturbing queued lines. While `pf_ready` is low, `pf_valid`, `pf_line` and `pf_kind` hold.
- R12: When all 16 entries are in use, a miss to a new page replaces the entry that was least recently allocated or touched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Demand access observed this cycle |
| req_miss | input | 1 | 1 for a cache miss, 0 for a hit |
| req_kind | input | 2 | Access type: 0 instruction, 1 read, 2 read-for-ownership |
| req_line | input | ADDR_W | Line address; low OFF_W bits are the offset in the page |
| pf_valid | output | 1 | Prefetch address available |
| pf_ready | input | 1 | Consumer takes the presented prefetch |
| pf_line | output | ADDR_W | Prefetch line address |
| pf_kind | output | 2 | Type of the stream that produced the prefetch |

## Verification
The bench sweeps the access offset across the top and bottom edges of a page in both directions. This separates full bursts from truncated ones and from the page hand-off case. Separate patterns probe training: a sequence with one step too few, a step past the window, a step of exactly the window, and a repeated line. Together they show when a stream starts issuing and when it loses its direction. Instruction streams are stepped backward to show that they ignore direction. Hits to unknown pages show that hits never allocate. A fill of all sixteen entries followed by one extra page shows which entry is replaced. The output is held stalled while a second burst arrives, which shows that queued lines survive and that the excess is dropped.

// File: rtl/pfx_pkg.sv
// Shared types for the page-bounded stream prefetcher.
// Assumes the request type encoding is fixed by the cache pipeline.
package pfx_pkg;

    typedef enum logic [1:0] {
        KIND_CODE = 2'd0,
        KIND_READ = 2'd1,
        KIND_RFO  = 2'd2
    } req_kind_e;

    // Training progress of one stream entry.
    typedef enum logic [2:0] {
        TR_IDLE = 3'd0,
        TR_UP1  = 3'd1,
        TR_DN1  = 3'd2,
        TR_UP   = 3'd3,
        TR_DN   = 3'd4
    } train_e;

endpackage

// File: rtl/pfx_stream_table.sv
// Stream table: finds the entry covering the page of a request, or
// allocates one on a miss. Trains the entry's direction and decides
// whether a burst is issued and whether it is a page hand-off.
// Replacement is exact LRU: the ages always form a permutation of
// 0..N-1, and age N-1 marks the victim.
// Assumes at most one request per cycle and that N is a power of two.
module pfx_stream_table
    import pfx_pkg::*;
#(
    parameter int N      = 16,
    parameter int ADDR_W = 29,
    parameter int OFF_W  = 6,
    parameter int WIN    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_miss,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_line,
    output logic              iss_valid,
    output logic              iss_up,
    output logic              iss_handoff,
    output logic [1:0]        iss_kind
);

    localparam int PAGE_W = ADDR_W - OFF_W;
    localparam int IDX_W  = $clog2(N);
    localparam int AGE_W  = IDX_W;
    localparam logic [OFF_W-1:0] MAX_OFF = {OFF_W{1'b1}};
    localparam logic [OFF_W:0]   WIN_L   = (OFF_W+1)'(WIN);
    localparam logic [AGE_W-1:0] OLDEST  = AGE_W'(N - 1);

    logic [N-1:0]        vld;
    logic [PAGE_W-1:0]   pg   [N];
    logic [OFF_W-1:0]    last [N];
    train_e              st   [N];
    logic [1:0]          knd  [N];
    logic [AGE_W-1:0]    age  [N];

    logic [PAGE_W-1:0]   page_in;
    logic [OFF_W-1:0]    off_in;
    logic [PAGE_W-1:0]   nxt_page;
    logic [N-1:0]        hit_vec, free_vec, oldest_vec, nxt_vec;
    logic                hit_any, free_any;
    logic [IDX_W-1:0]    hit_idx, free_idx, old_idx, sel;

    logic                upd, issue, up, handoff;
    logic                n_vld;
    logic [PAGE_W-1:0]   n_pg;
    logic [OFF_W-1:0]    n_last;
    train_e              n_st;
    logic [1:0]          n_knd;
    logic [OFF_W:0]      mag;
    logic                step_up, step_dn;

    assign page_in = req_line[ADDR_W-1:OFF_W];
    assign off_in  = req_line[OFF_W-1:0];

    // Per-entry comparators against the request page and the hand-off page.
    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign hit_vec[i]    = vld[i] && (pg[i] == page_in);
        assign nxt_vec[i]    = vld[i] && (pg[i] == nxt_page);
        assign free_vec[i]   = !vld[i];
        assign oldest_vec[i] = (age[i] == OLDEST);
    end

    // Priority encoders: matching entry, lowest free entry, oldest entry.
    always_comb begin
        hit_any  = 1'b0;
        free_any = 1'b0;
        hit_idx  = '0;
        free_idx = '0;
        old_idx  = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                hit_any = 1'b1;
                hit_idx = IDX_W'(i);
            end
            if (free_vec[i]) begin
                free_any = 1'b1;
                free_idx = IDX_W'(i);
            end
            if (oldest_vec[i]) old_idx = IDX_W'(i);
        end
    end

    // Step size and sign relative to the last access of the matching entry.
    always_comb begin
        step_up = off_in > last[hit_idx];
        step_dn = off_in < last[hit_idx];
        if (step_up)
            mag = {1'b0, off_in} - {1'b0, last[hit_idx]};
        else
            mag = {1'b0, last[hit_idx]} - {1'b0, off_in};
    end

    // Next-state decision for the touched or allocated entry.
    always_comb begin
        upd    = 1'b0;
        issue  = 1'b0;
        sel    = hit_idx;
        n_vld  = 1'b1;
        n_pg   = page_in;
        n_last = off_in;
        n_st   = st[hit_idx];
        n_knd  = knd[hit_idx];
        if (req_valid && hit_any) begin
            upd = 1'b1;
            if (knd[hit_idx] == KIND_CODE) begin
                n_st  = TR_UP;
                issue = 1'b1;
            end else if (!step_up && !step_dn) begin
                n_last = last[hit_idx];
            end else if (mag > WIN_L) begin
                n_st = TR_IDLE;
            end else if (step_up) begin
                n_st  = (st[hit_idx] == TR_UP1 || st[hit_idx] == TR_UP) ? TR_UP : TR_UP1;
                issue = (n_st == TR_UP);
            end else begin
                n_st  = (st[hit_idx] == TR_DN1 || st[hit_idx] == TR_DN) ? TR_DN : TR_DN1;
                issue = (n_st == TR_DN);
            end
        end else if (req_valid && req_miss) begin
            upd   = 1'b1;
            sel   = free_any ? free_idx : old_idx;
            n_knd = req_kind;
            if (req_kind == KIND_CODE) begin
                n_st  = TR_UP;
                issue = 1'b1;
            end else begin
                n_st = TR_IDLE;
            end
        end
        up       = (n_st == TR_UP);
        handoff  = issue && (up ? (off_in == MAX_OFF) : (off_in == '0));
        nxt_page = up ? page_in + 1'b1 : page_in - 1'b1;
        if (handoff) begin
            if ((nxt_vec & ~(N'(1) << sel)) != '0) begin
                n_vld = 1'b0;
            end else begin
                n_pg   = nxt_page;
                n_last = up ? '0 : MAX_OFF;
            end
        end
    end

    assign iss_valid   = issue;
    assign iss_up      = up;
    assign iss_handoff = handoff;
    assign iss_kind    = n_knd;

    // Entry storage and LRU age update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld <= '0;
            for (int i = 0; i < N; i++) begin
                pg[i]   <= '0;
                last[i] <= '0;
                st[i]   <= TR_IDLE;
                knd[i]  <= '0;
                age[i]  <= AGE_W'(i);
            end
        end else if (upd) begin
            for (int i = 0; i < N; i++) begin
                if (IDX_W'(i) == sel) begin
                    vld[i]  <= n_vld;
                    pg[i]   <= n_pg;
                    last[i] <= n_last;
                    st[i]   <= n_st;
                    knd[i]  <= n_knd;
                    age[i]  <= '0;
                end else if (age[i] < age[sel]) begin
                    age[i] <= age[i] + 1'b1;
                end
            end
        end
    end

    p_single_page_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));
    p_hit_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_miss && !hit_any) |=> $stable(vld));
    p_age_order_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(oldest_vec) == 1);
    p_code_forward_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_kind == KIND_CODE) |-> iss_up);

endmodule

// File: rtl/pfx_burst_gen.sv
// Burst generator: expands one issue into up to BURST candidate line
// addresses, nearest first, trimmed at the page edge. A hand-off issue
// produces a single candidate in the adjacent page.
// Purely combinational; assumes base_line is the triggering access.
module pfx_burst_gen #(
    parameter int ADDR_W = 29,
    parameter int OFF_W  = 6,
    parameter int BURST  = 4
) (
    input  logic                          iss_valid,
    input  logic                          iss_up,
    input  logic                          iss_handoff,
    input  logic [ADDR_W-1:0]             base_line,
    output logic [BURST-1:0]              cand_vld,
    output logic [BURST-1:0][ADDR_W-1:0]  cand_line
);

    localparam int PAGE_W = ADDR_W - OFF_W;
    localparam logic [OFF_W-1:0] MAX_OFF = {OFF_W{1'b1}};

    logic [PAGE_W-1:0] page;
    logic [OFF_W-1:0]  off;

    assign page = base_line[ADDR_W-1:OFF_W];
    assign off  = base_line[OFF_W-1:0];

    for (genvar k = 0; k < BURST; k++) begin : g_cand
        localparam logic [OFF_W:0] STEP = (OFF_W+1)'(k + 1);
        logic [OFF_W:0] up_sum;
        logic [OFF_W:0] dn_dif;
        assign up_sum = {1'b0, off} + STEP;
        assign dn_dif = {1'b0, off} - STEP;

        // One candidate: in-page step, or the hand-off line for slot 0.
        always_comb begin
            if (iss_handoff) begin
                cand_vld[k]  = iss_valid && (k == 0);
                cand_line[k] = iss_up ? {page + 1'b1, {OFF_W{1'b0}}}
                                      : {page - 1'b1, MAX_OFF};
            end else if (iss_up) begin
                cand_vld[k]  = iss_valid && !up_sum[OFF_W];
                cand_line[k] = {page, up_sum[OFF_W-1:0]};
            end else begin
                cand_vld[k]  = iss_valid && !dn_dif[OFF_W];
                cand_line[k] = {page, dn_dif[OFF_W-1:0]};
            end
        end
    end

endmodule

// File: rtl/pfx_out_queue.sv
// Output queue: circular buffer that accepts up to NIN entries per cycle
// into free slots only. Entries that do not fit are dropped, and queued
// entries are never overwritten. Presents its head on a valid/ready port.
// Assumes DEPTH is a power of two.
module pfx_out_queue #(
    parameter int W     = 31,
    parameter int DEPTH = 4,
    parameter int NIN   = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NIN-1:0]         in_vld,
    input  logic [NIN-1:0][W-1:0]  in_data,
    output logic                   out_valid,
    input  logic                   out_ready,
    output logic [W-1:0]           out_data
);

    localparam int PTR_W = $clog2(DEPTH);
    localparam int SUM_W = $clog2(NIN + DEPTH + 1) + 1;

    logic [W-1:0]       mem [DEPTH];
    logic [PTR_W-1:0]   rd_ptr, wr_ptr;
    logic [SUM_W-1:0]   count, free, n_push;
    logic [SUM_W-1:0]   rank [NIN];
    logic [NIN-1:0]     wen;
    logic [PTR_W-1:0]   waddr [NIN];
    logic               pop;

    assign free      = SUM_W'(DEPTH) - count;
    assign out_valid = (count != '0);
    assign out_data  = mem[rd_ptr];
    assign pop       = out_valid && out_ready;

    // Rank each valid input among the valid ones and gate by free space.
    always_comb begin
        n_push = '0;
        for (int i = 0; i < NIN; i++) begin
            rank[i]  = n_push;
            wen[i]   = in_vld[i] && (n_push < free);
            waddr[i] = wr_ptr + PTR_W'(n_push);
            if (wen[i]) n_push = n_push + 1'b1;
        end
    end

    // Slot writes for accepted entries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < DEPTH; s++) mem[s] <= '0;
        end else begin
            for (int i = 0; i < NIN; i++) begin
                if (wen[i]) mem[waddr[i]] <= in_data[i];
            end
        end
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            wr_ptr <= wr_ptr + PTR_W'(n_push);
            if (pop) rd_ptr <= rd_ptr + 1'b1;
            count <= count + n_push - SUM_W'(pop);
        end
    end

    p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        count <= SUM_W'(DEPTH));
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
    p_rank_order_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wen[NIN-1] |-> rank[NIN-1] < free));

endmodule

// File: rtl/page_stream_prefetcher.sv
// Top of the page-bounded stream prefetcher. Chains the stream table,
// the burst generator and the output queue. One request may arrive per
// cycle; its prefetches become visible on the output one cycle later.
module page_stream_prefetcher
    import pfx_pkg::*;
#(
    parameter int N_STREAMS = 16,
    parameter int ADDR_W    = 29,
    parameter int OFF_W     = 6,
    parameter int WIN       = 16,
    parameter int BURST     = 4,
    parameter int QDEPTH    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_miss,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_line,
    output logic              pf_valid,
    input  logic              pf_ready,
    output logic [ADDR_W-1:0] pf_line,
    output logic [1:0]        pf_kind
);

    localparam int QW = ADDR_W + 2;

    logic                          iss_valid, iss_up, iss_handoff;
    logic [1:0]                    iss_kind;
    logic [BURST-1:0]              cand_vld;
    logic [BURST-1:0][ADDR_W-1:0]  cand_line;
    logic [BURST-1:0][QW-1:0]      cand_data;
    logic [QW-1:0]                 q_data;

    pfx_stream_table #(
        .N(N_STREAMS), .ADDR_W(ADDR_W), .OFF_W(OFF_W), .WIN(WIN)
    ) u_table (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_miss(req_miss),
        .req_kind(req_kind), .req_line(req_line),
        .iss_valid(iss_valid), .iss_up(iss_up),
        .iss_handoff(iss_handoff), .iss_kind(iss_kind)
    );

    pfx_burst_gen #(
        .ADDR_W(ADDR_W), .OFF_W(OFF_W), .BURST(BURST)
    ) u_burst (
        .iss_valid(iss_valid), .iss_up(iss_up), .iss_handoff(iss_handoff),
        .base_line(req_line), .cand_vld(cand_vld), .cand_line(cand_line)
    );

    // Attach the stream type to each candidate line.
    for (genvar k = 0; k < BURST; k++) begin : g_pack
        assign cand_data[k] = {cand_line[k], iss_kind};
    end

    pfx_out_queue #(
        .W(QW), .DEPTH(QDEPTH), .NIN(BURST)
    ) u_queue (
        .clk(clk), .rst_n(rst_n),
        .in_vld(cand_vld), .in_data(cand_data),
        .out_valid(pf_valid), .out_ready(pf_ready), .out_data(q_data)
    );

    assign pf_line = q_data[QW-1:2];
    assign pf_kind = q_data[1:0];

    p_kind_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |-> (pf_kind != 2'd3));

    for (genvar k = 0; k < BURST; k++) begin : g_chk
        p_in_page_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (cand_vld[k] && !iss_handoff) |->
            (cand_line[k][ADDR_W-1:OFF_W] == req_line[ADDR_W-1:OFF_W]));
    end

endmodule

// File: tb/page_stream_prefetcher_bench.sv
`timescale 1ns/1ps
module page_stream_prefetcher_bench;

    localparam int AW = 29;
    localparam int OW = 6;
    localparam int PW = AW - OW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_miss = 1'b0;
    logic [1:0]    req_kind = 2'd0;
    logic [AW-1:0] req_line = '0;
    logic          pf_valid;
    logic          pf_ready = 1'b0;
    logic [AW-1:0] pf_line;
    logic [1:0]    pf_kind;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [AW-1:0] got_line [8];
    logic [1:0]    got_kind [8];
    int            got_n;

    always #2 clk = ~clk;

    page_stream_prefetcher u_page_stream_prefetcher (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_miss(req_miss),
        .req_kind(req_kind), .req_line(req_line),
        .pf_valid(pf_valid), .pf_ready(pf_ready),
        .pf_line(pf_line), .pf_kind(pf_kind)
    );

    function automatic logic [AW-1:0] mk(input int page, input int off);
        return {PW'(page), OW'(off)};
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic send(input bit miss, input int kind, input int page, input int off);
        req_valid = 1'b1;
        req_miss  = miss;
        req_kind  = 2'(kind);
        req_line  = mk(page, off);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic drain();
        got_n = 0;
        pf_ready = 1'b1;
        for (int i = 0; i < 8; i++) begin
            if (pf_valid) begin
                got_line[got_n] = pf_line;
                got_kind[got_n] = pf_kind;
                got_n++;
            end
            @(negedge clk);
        end
        pf_ready = 1'b0;
    endtask

    // Drain and compare with lines start+dir*k, k = 1..n, in one page.
    task automatic exp_burst(input string tag, input int page, input int start,
                             input int dir, input int n, input int kind);
        drain();
        chk(got_n == n, {tag, " count"}, got_n, n);
        for (int k = 1; k <= n && k <= got_n; k++) begin
            chk(got_line[k-1] == mk(page, start + dir * k), {tag, " line"},
                got_line[k-1], mk(page, start + dir * k));
            chk(got_kind[k-1] == 2'(kind), {tag, " kind"}, got_kind[k-1], kind);
        end
    endtask

    task automatic exp_one(input string tag, input int page, input int off, input int kind);
        drain();
        chk(got_n == 1, {tag, " count"}, got_n, 1);
        chk(got_line[0] == mk(page, off), {tag, " line"}, got_line[0], mk(page, off));
        chk(got_kind[0] == 2'(kind), {tag, " kind"}, got_kind[0], kind);
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();
        chk(pf_valid == 1'b0, "R1 reset valid", pf_valid, 0);
        drain();
        chk(got_n == 0, "R1 reset empty queue", got_n, 0);

        // R2: hits to an uncovered page never allocate.
        send(0, 1, 300, 10); send(0, 1, 300, 11); send(0, 1, 300, 12);
        exp_burst("R2 hits ignored", 300, 12, 1, 0, 1);
        send(1, 1, 300, 13); send(0, 1, 300, 14); send(0, 1, 300, 15);
        exp_burst("R2 miss allocates", 300, 15, 1, 4, 1);

        // R3/R4: ascending read stream confirms on the second step.
        send(1, 1, 10, 10); send(0, 1, 10, 11);
        exp_burst("R3 one step silent", 10, 11, 1, 0, 1);
        send(0, 1, 10, 12);
        exp_burst("R4 ascending burst", 10, 12, 1, 4, 1);

        // R5/R9: descending read-for-ownership stream.
        send(1, 2, 20, 20); send(1, 2, 20, 19); send(0, 2, 20, 18);
        exp_burst("R5 descending burst R9 kind", 20, 18, -1, 4, 2);

        // R6: instruction streams run upward from the first miss.
        send(1, 0, 30, 5);
        exp_burst("R6 code first miss", 30, 5, 1, 4, 0);
        send(0, 0, 30, 3);
        exp_burst("R6 code backward step", 30, 3, 1, 4, 0);
        send(0, 0, 30, 62);
        exp_burst("R6 R7 code near edge", 30, 62, 1, 1, 0);

        // R7: sweep of the top and bottom page edges.
        for (int s = 56; s <= 62; s++) begin
            send(1, 1, 400 + s, s - 2); send(0, 1, 400 + s, s - 1); send(0, 1, 400 + s, s);
            exp_burst("R7 top edge", 400 + s, s, 1, (63 - s) < 4 ? 63 - s : 4, 1);
        end
        for (int s = 1; s <= 7; s++) begin
            send(1, 1, 500 + s, s + 2); send(0, 1, 500 + s, s + 1); send(0, 1, 500 + s, s);
            exp_burst("R7 bottom edge", 500 + s, s, -1, s < 4 ? s : 4, 1);
        end

        // R8: hand-off upward and downward.
        send(1, 1, 40, 60); send(0, 1, 40, 61); send(0, 1, 40, 62);
        exp_burst("R8 before top", 40, 62, 1, 1, 1);
        send(0, 1, 40, 63);
        exp_one("R8 handoff up", 41, 0, 1);
        send(0, 1, 41, 1);
        exp_burst("R8 continued page up", 41, 1, 1, 4, 1);
        send(1, 2, 50, 3); send(0, 2, 50, 2); send(0, 2, 50, 1);
        exp_burst("R8 before bottom", 50, 1, -1, 1, 2);
        send(0, 2, 50, 0);
        exp_one("R8 handoff down", 49, 63, 2);
        send(0, 2, 49, 62);
        exp_burst("R8 continued page down", 49, 62, -1, 4, 2);

        // R10: window limit and repeated line.
        send(1, 1, 60, 10); send(0, 1, 60, 11); send(0, 1, 60, 40); send(0, 1, 60, 41);
        exp_burst("R10 jump resets", 60, 41, 1, 0, 1);
        send(0, 1, 60, 42);
        exp_burst("R10 retrained", 60, 42, 1, 4, 1);
        send(0, 1, 60, 42);
        exp_burst("R10 repeat silent", 60, 42, 1, 0, 1);
        send(0, 1, 60, 58);
        exp_burst("R10 step of WIN", 60, 58, 1, 4, 1);

        // R11: stalled output keeps its contents; the excess is dropped.
        send(1, 1, 70, 10); send(0, 1, 70, 11); send(0, 1, 70, 12);
        send(0, 1, 70, 13);
        chk(pf_line == mk(70, 13), "R11 head before stall", pf_line, mk(70, 13));
        repeat (3) @(negedge clk);
        chk(pf_valid && pf_line == mk(70, 13), "R11 hold while stalled", pf_line, mk(70, 13));
        exp_burst("R11 full queue kept", 70, 12, 1, 4, 1);
        send(0, 1, 70, 20);
        exp_burst("R11 refill after drain", 70, 20, 1, 4, 1);

        // R12: LRU replacement after reset.
        do_reset();
        for (int p = 0; p < 16; p++) send(1, 1, 1000 + p, 10);
        send(0, 1, 1000, 10);
        send(1, 1, 2000, 10);
        send(0, 1, 1000, 11); send(0, 1, 1000, 12);
        exp_burst("R12 touched entry kept", 1000, 12, 1, 4, 1);
        send(0, 1, 1001, 11); send(0, 1, 1001, 12);
        exp_burst("R12 oldest entry replaced", 1001, 12, 1, 0, 1);
        send(0, 1, 1002, 11); send(0, 1, 1002, 12);
        exp_burst("R12 next entry kept", 1002, 12, 1, 4, 1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule